// File: doc/BRIEF.md
# Register-Mapped Serial Port

This block is a small serial transmitter and receiver that sits on a Wishbone-style classic slave port. The port has a two-bit word address and 32-bit data. Four words are visible on it:

- a status word;
- the oversampling divider;
- the transmit byte;
- the last received byte.

All logic runs in one clock domain. The divider sets a tick rate of sixteen ticks per bit. The transmitter shifts out one frame per accepted write. The receiver passes its line input through a two-flop synchroniser. It samples each bit at its centre and keeps the byte until software reads it.

Each serial frame is one low start bit, eight data bits sent least significant bit first, and one high stop bit. The line idles high. Software uses the port in this way:

- It writes the divider once.
- It polls status bit 0 before each transmit write.
- It polls status bit 1 before it reads a received byte.

There is no back-pressure at the serial side. A byte that arrives before the previous one is read overwrites it.

Top module: `uart_regport`

## Requirements
- R1: After reset the status word reads 0, the divider word reads the default DIV_RESET (27), the receive word reads 0 and the TX line is high.
- R2: Every bus access with cycle and strobe both high is acknowledged exactly one clock after it is accepted, and only once. All read bits above the field width read as zero: bits 31:2 of status, 31:16 of the divider, and 31:8 of the TX and RX words.
- R3: A write to word 1 replaces the divider, and a read of word 1 returns the stored value. One tick occurs every `divider` clocks; a divider of 0 acts as 1.
- R4: A write to word 2 sends bits 7:0 of the write data as a frame. The frame is a low start bit, then 8 data bits LSB first, then a high stop bit. Each bit lasts 16 ticks, except the start bit, which may be shortened by less than one tick.
- R5: Status bit 0 (TX busy) reads 1 from the first cycle after a write to word 2 is accepted until the stop bit has been sent, and reads 0 afterwards.
- R6: A write to word 2 while TX busy reads 1 is ignored. It sends no frame and does not change the byte returned by word 2.
- R7: A read of word 2 returns, in bits 7:0, the byte of the last accepted transmit write.
- R8: A frame received with a high stop bit sets status bit 1 (RX ready), and word 3 returns its byte.
- R9: A read of word 3 clears RX ready. If a new byte completes in that same cycle, RX ready stays set.
- R10: A write to word 3 changes neither the received byte nor RX ready.
- R11: A low pulse on RX that has ended before the midpoint of the start bit (8 ticks) is rejected. No byte is received.
- R12: A frame whose stop bit is low is dropped and does not set RX ready. The receiver waits for the line to return high before it looks for a new start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_cyc_i | input | 1 | Bus cycle active |
| bus_stb_i | input | 1 | Bus strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_adr_i | input | 2 | Word address: 0 status, 1 divider, 2 TX byte, 3 RX byte |
| bus_dat_i | input | 32 | Write data |
| bus_dat_o | output | 32 | Read data, valid while ack is high |
| bus_ack_o | output | 1 | Acknowledge, one cycle after acceptance |
| ser_tx_o | output | 1 | Serial transmit line, idles high |
| ser_rx_i | input | 1 | Serial receive line, asynchronous |

## Verification
Two functions can meet in the same cycle. The first meeting is a transmit write that arrives while the transmitter is still busy. The bench provokes it by issuing a second write to word 2 back to back with the first. It then judges the result at the serial pin: only the first byte may appear there, and word 2 must still read back the first byte. The second meeting is a status read in the cycle right after a transmit write is accepted, before the shift engine has started. That read must already report busy.

// File: rtl/uart_regport_pkg.sv
package uart_regport_pkg;
  localparam int unsigned OSR = 16;
  localparam int unsigned DATA_BITS = 8;

  localparam logic [1:0] ADR_STATUS = 2'd0;
  localparam logic [1:0] ADR_DIV    = 2'd1;
  localparam logic [1:0] ADR_TXB    = 2'd2;
  localparam logic [1:0] ADR_RXB    = 2'd3;

  typedef enum logic [1:0] {
    TX_IDLE  = 2'd0,
    TX_START = 2'd1,
    TX_DATA  = 2'd2,
    TX_STOP  = 2'd3
  } tx_state_t;

  typedef enum logic [2:0] {
    RX_IDLE  = 3'd0,
    RX_START = 3'd1,
    RX_DATA  = 3'd2,
    RX_STOP  = 3'd3,
    RX_BREAK = 3'd4
  } rx_state_t;
endpackage

// File: rtl/uart_tick_gen.sv
module uart_tick_gen #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == '0) begin
      cnt  <= (div == '0) ? '0 : div - 1'b1;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt - 1'b1;
      tick <= 1'b0;
    end
  end

  // R3: with a steady divider above one, ticks never come back to back
  assert_tick_gap_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && div > 1 && $past(div) == div) |=> !tick);
endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine
  import uart_regport_pkg::*;
#(
  parameter int unsigned NBITS = DATA_BITS,
  parameter int unsigned OVS   = OSR
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [NBITS-1:0] data,
  output logic             busy,
  output logic             txd
);
  localparam int unsigned CW = $clog2(OVS);
  localparam int unsigned BW = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(OVS - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(NBITS - 1);

  tx_state_t        state;
  logic [CW-1:0]    tcnt;
  logic [BW-1:0]    bitn;
  logic [NBITS-1:0] shreg;

  assign busy = (state != TX_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= TX_IDLE;
      tcnt  <= '0;
      bitn  <= '0;
      shreg <= '0;
      txd   <= 1'b1;
    end else if (state == TX_IDLE) begin
      if (load) begin
        state <= TX_START;
        shreg <= data;
        tcnt  <= '0;
        txd   <= 1'b0;
      end
    end else if (tick) begin
      if (tcnt != CNT_LAST) begin
        tcnt <= tcnt + 1'b1;
      end else begin
        tcnt <= '0;
        unique case (state)
          TX_START: begin
            state <= TX_DATA;
            bitn  <= '0;
            txd   <= shreg[0];
            shreg <= shreg >> 1;
          end
          TX_DATA: begin
            if (bitn == BIT_LAST) begin
              state <= TX_STOP;
              txd   <= 1'b1;
            end else begin
              bitn  <= bitn + 1'b1;
              txd   <= shreg[0];
              shreg <= shreg >> 1;
            end
          end
          default: begin
            state <= TX_IDLE;
            txd   <= 1'b1;
          end
        endcase
      end
    end
  end

  // R4: the line is high whenever no frame is in flight
  assert_idle_high_R4: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);
  // R4: a frame always opens with a low start bit
  assert_start_low_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !txd);
endmodule

// File: rtl/uart_rx_engine.sv
module uart_rx_engine
  import uart_regport_pkg::*;
#(
  parameter int unsigned NBITS = DATA_BITS,
  parameter int unsigned OVS   = OSR
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             rxd_async,
  output logic [NBITS-1:0] rx_byte,
  output logic             rx_stb
);
  localparam int unsigned CW = $clog2(OVS);
  localparam int unsigned BW = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(OVS - 1);
  localparam logic [CW-1:0] CNT_MID  = CW'(OVS / 2 - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(NBITS - 1);

  logic             sync1, rxs;
  rx_state_t        state;
  logic [CW-1:0]    rcnt;
  logic [BW-1:0]    bitn;
  logic [NBITS-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= 1'b1;
      rxs   <= 1'b1;
    end else begin
      sync1 <= rxd_async;
      rxs   <= sync1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= RX_IDLE;
      rcnt    <= '0;
      bitn    <= '0;
      shreg   <= '0;
      rx_byte <= '0;
      rx_stb  <= 1'b0;
    end else begin
      rx_stb <= 1'b0;
      unique case (state)
        RX_IDLE: begin
          if (!rxs) begin
            state <= RX_START;
            rcnt  <= '0;
          end
        end
        RX_START: begin
          if (tick) begin
            if (rcnt == CNT_MID) begin
              rcnt  <= '0;
              bitn  <= '0;
              state <= rxs ? RX_IDLE : RX_DATA;
            end else begin
              rcnt <= rcnt + 1'b1;
            end
          end
        end
        RX_DATA: begin
          if (tick) begin
            if (rcnt == CNT_LAST) begin
              rcnt  <= '0;
              shreg <= {rxs, shreg[NBITS-1:1]};
              if (bitn == BIT_LAST) state <= RX_STOP;
              else bitn <= bitn + 1'b1;
            end else begin
              rcnt <= rcnt + 1'b1;
            end
          end
        end
        RX_STOP: begin
          if (tick) begin
            if (rcnt == CNT_LAST) begin
              rcnt <= '0;
              if (rxs) begin
                rx_byte <= shreg;
                rx_stb  <= 1'b1;
                state   <= RX_IDLE;
              end else begin
                state <= RX_BREAK;
              end
            end else begin
              rcnt <= rcnt + 1'b1;
            end
          end
        end
        default: begin
          if (rxs) state <= RX_IDLE;
        end
      endcase
    end
  end

  // R8: a byte is only delivered when the sampled stop bit was high
  assert_stop_high_R8: assert property (@(posedge clk) disable iff (rst)
    rx_stb |-> $past(rxs));
  // R12: after a low stop bit no byte leaves until the line has been high
  assert_break_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (state == RX_BREAK) |-> !rx_stb);
endmodule

// File: rtl/uart_regport.sv
module uart_regport
  import uart_regport_pkg::*;
#(
  parameter int unsigned DIV_W     = 16,
  parameter int unsigned DIV_RESET = 27,
  parameter int unsigned DW        = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_cyc_i,
  input  logic          bus_stb_i,
  input  logic          bus_we_i,
  input  logic [1:0]    bus_adr_i,
  input  logic [DW-1:0] bus_dat_i,
  output logic [DW-1:0] bus_dat_o,
  output logic          bus_ack_o,
  output logic          ser_tx_o,
  input  logic          ser_rx_i
);
  localparam int unsigned NB = DATA_BITS;

  logic [DIV_W-1:0] div_q;
  logic [NB-1:0]    tx_hold;
  logic [NB-1:0]    rx_data;
  logic             rx_ready;
  logic             tx_load;
  logic             tx_busy;
  logic             tick;
  logic [NB-1:0]    rx_byte;
  logic             rx_stb;
  logic             tx_busy_any;

  logic acc, wr, rd;
  assign acc = bus_cyc_i && bus_stb_i && !bus_ack_o;
  assign wr  = acc && bus_we_i;
  assign rd  = acc && !bus_we_i;
  assign tx_busy_any = tx_busy || tx_load;

  logic [DW-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    unique case (bus_adr_i)
      ADR_STATUS: rd_mux[1:0]       = {rx_ready, tx_busy_any};
      ADR_DIV:    rd_mux[DIV_W-1:0] = div_q;
      ADR_TXB:    rd_mux[NB-1:0]    = tx_hold;
      default:    rd_mux[NB-1:0]    = rx_data;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_ack_o <= 1'b0;
      bus_dat_o <= '0;
      div_q     <= DIV_W'(DIV_RESET);
      tx_hold   <= '0;
      tx_load   <= 1'b0;
      rx_data   <= '0;
      rx_ready  <= 1'b0;
    end else begin
      bus_ack_o <= acc;
      tx_load   <= 1'b0;
      if (rd) bus_dat_o <= rd_mux;
      if (wr && bus_adr_i == ADR_DIV) div_q <= bus_dat_i[DIV_W-1:0];
      if (wr && bus_adr_i == ADR_TXB && !tx_busy_any) begin
        tx_hold <= bus_dat_i[NB-1:0];
        tx_load <= 1'b1;
      end
      if (rx_stb) begin
        rx_data  <= rx_byte;
        rx_ready <= 1'b1;
      end else if (rd && bus_adr_i == ADR_RXB) begin
        rx_ready <= 1'b0;
      end
    end
  end

  uart_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .div(div_q), .tick(tick)
  );

  uart_tx_engine #(.NBITS(NB), .OVS(OSR)) u_tx (
    .clk(clk), .rst(rst), .tick(tick), .load(tx_load),
    .data(tx_hold), .busy(tx_busy), .txd(ser_tx_o)
  );

  uart_rx_engine #(.NBITS(NB), .OVS(OSR)) u_rx (
    .clk(clk), .rst(rst), .tick(tick), .rxd_async(ser_rx_i),
    .rx_byte(rx_byte), .rx_stb(rx_stb)
  );

  // R2: an acknowledge only follows a cycle with cycle and strobe high
  assert_ack_follows_R2: assert property (@(posedge clk) disable iff (rst)
    bus_ack_o |-> $past(bus_cyc_i && bus_stb_i));
  // R2: byte-wide words carry zeros in their upper bits
  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_ack_o && $past(!bus_we_i) && $past(bus_adr_i) >= ADR_TXB)
      |-> bus_dat_o[DW-1:NB] == '0);
  // R6: a transmit write made while busy leaves the held byte alone
  assert_busy_write_R6: assert property (@(posedge clk) disable iff (rst)
    (wr && bus_adr_i == ADR_TXB && tx_busy) |=> $stable(tx_hold));
  // R10: a bus write never alters the received byte
  assert_rx_wr_R10: assert property (@(posedge clk) disable iff (rst)
    (wr && bus_adr_i == ADR_RXB && !rx_stb) |=> $stable(rx_data));
endmodule

// File: tb/tb_uart_regport.sv
module tb_uart_regport;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic [1:0]  adr = 2'd0;
  logic [31:0] dat_i = '0;
  logic [31:0] dat_o;
  logic        ack;
  logic        txd;
  logic        rxd = 1'b1;

  int checks = 0;
  int errors = 0;
  int cur_div = 27;
  logic exp_ack = 1'b0;
  logic [7:0] txq[$];

  always #5 clk = ~clk;

  uart_regport dut (
    .clk(clk), .rst(rst), .bus_cyc_i(cyc), .bus_stb_i(stb), .bus_we_i(we),
    .bus_adr_i(adr), .bus_dat_i(dat_i), .bus_dat_o(dat_o), .bus_ack_o(ack),
    .ser_tx_o(txd), .ser_rx_i(rxd)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // per-clock model of the acknowledge (R2)
  always @(negedge clk) begin
    if (rst) exp_ack = 1'b0;
    else begin
      if (ack || exp_ack) chk("R2 ack timing", {31'd0, ack}, {31'd0, exp_ack});
      exp_ack = cyc && stb && !exp_ack;
    end
  end

  // serial monitor decoding frames at the TX pin (R4)
  initial begin
    forever begin
      @(negedge txd);
      if (!rst) begin
        logic [7:0] b;
        int bt;
        bt = 16 * cur_div;
        repeat (bt / 2) @(negedge clk);
        chk("R4 start bit", {31'd0, txd}, 32'd0);
        for (int i = 0; i < 8; i++) begin
          repeat (bt) @(negedge clk);
          b[i] = txd;
        end
        repeat (bt) @(negedge clk);
        chk("R4 stop bit", {31'd0, txd}, 32'd1);
        txq.push_back(b);
      end
    end
  end

  task automatic bus(input logic w, input logic [1:0] a, input logic [31:0] d,
                     output logic [31:0] q);
    @(posedge clk); #1;
    cyc = 1'b1; stb = 1'b1; we = w; adr = a; dat_i = d;
    @(negedge clk);
    while (!ack) @(negedge clk);
    q = dat_o;
    @(posedge clk); #1;
    cyc = 1'b0; stb = 1'b0; we = 1'b0;
  endtask

  task automatic rd_chk(input logic [1:0] a, input logic [31:0] exp, input string req);
    logic [31:0] q;
    bus(1'b0, a, 32'd0, q);
    chk(req, q, exp);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    logic [31:0] q;
    bus(1'b1, a, d, q);
  endtask

  task automatic send_rx(input logic [7:0] b, input logic stop);
    int bt;
    bt = 16 * cur_div;
    rxd = 1'b0;
    repeat (bt) @(posedge clk);
    for (int i = 0; i < 8; i++) begin
      #1 rxd = b[i];
      repeat (bt) @(posedge clk);
    end
    #1 rxd = stop;
    repeat (bt) @(posedge clk);
    #1 rxd = 1'b1;
    repeat (2 * bt) @(posedge clk);
  endtask

  task automatic wait_tx_done();
    repeat (170 * cur_div) @(posedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] q;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    chk("R1 tx idle high", {31'd0, txd}, 32'd1);
    rd_chk(2'd0, 32'd0, "R1 status after reset");
    rd_chk(2'd1, 32'd27, "R1 divider default");
    rd_chk(2'd3, 32'd0, "R1 rx byte after reset");

    // R3: divider replace and read back, upper bits dropped (R2)
    wr(2'd1, 32'hFFFF_0005);
    rd_chk(2'd1, 32'h0000_0005, "R3 divider readback");
    wr(2'd1, 32'd2);
    cur_div = 2;
    rd_chk(2'd1, 32'd2, "R3 divider readback 2");

    // R4/R5/R7: one frame, busy right after the write
    wr(2'd2, 32'hABCD_12A5);
    rd_chk(2'd0, 32'd1, "R5 busy right after load");
    rd_chk(2'd2, 32'h0000_00A5, "R7 tx byte readback");
    repeat (140 * cur_div) @(posedge clk);
    rd_chk(2'd0, 32'd1, "R5 busy before stop sent");
    wait_tx_done();
    rd_chk(2'd0, 32'd0, "R5 busy cleared");
    chk("R4 frame count", txq.size(), 32'd1);
    if (txq.size() > 0) chk("R4 frame byte", {24'd0, txq.pop_front()}, 32'hA5);

    // R6: back-to-back writes, the second is ignored
    wr(2'd2, 32'h3C);
    wr(2'd2, 32'hC3);
    rd_chk(2'd2, 32'h3C, "R6 hold unchanged");
    wait_tx_done();
    repeat (20 * cur_div) @(posedge clk);
    chk("R6 one frame only", txq.size(), 32'd1);
    if (txq.size() > 0) chk("R6 frame byte", {24'd0, txq.pop_front()}, 32'h3C);

    // different pattern, LSB-first
    wr(2'd2, 32'h01);
    wait_tx_done();
    chk("R4 frame count 2", txq.size(), 32'd1);
    if (txq.size() > 0) chk("R4 lsb first", {24'd0, txq.pop_front()}, 32'h01);

    // R8/R9/R10: receive path
    send_rx(8'h5A, 1'b1);
    rd_chk(2'd0, 32'd2, "R8 rx ready set");
    wr(2'd3, 32'hFF);
    rd_chk(2'd0, 32'd2, "R10 ready kept after write");
    rd_chk(2'd3, 32'h5A, "R8 rx byte");
    rd_chk(2'd0, 32'd0, "R9 ready cleared by read");
    send_rx(8'hC1, 1'b1);
    rd_chk(2'd3, 32'hC1, "R8 second rx byte");

    // R11: short start pulse
    #1 rxd = 1'b0;
    repeat (3 * cur_div) @(posedge clk);
    #1 rxd = 1'b1;
    repeat (200 * cur_div) @(posedge clk);
    rd_chk(2'd0, 32'd0, "R11 glitch rejected");
    rd_chk(2'd3, 32'hC1, "R11 byte unchanged");

    // R12: low stop bit
    send_rx(8'h77, 1'b0);
    rd_chk(2'd0, 32'd0, "R12 framing drop");
    rd_chk(2'd3, 32'hC1, "R12 byte unchanged");
    send_rx(8'h96, 1'b1);
    rd_chk(2'd3, 32'h96, "R12 recovery after break");

    chk("R4 no stray frames", txq.size(), 32'd0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule